// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate into a linear address inside a two-dimensional tiled container. The caller presents a pixel format, a three-bit orientation and an (x, y) pair together with a valid strobe. One clock later the block returns the tiled-space address, an error flag for coordinates outside the container, and per-format helper values: slot width and height in pixels, bytes per pixel, and row stride in bytes.

Each format leaves some low coordinate bits unused. The block first checks each coordinate against the range of its field. It then mirrors x and/or y within that field if asked, packs the two fields in row-major or swapped order, and shifts the packed value left by the total number of unused bits. The top bits of the address carry the orientation and the format code, so a downstream decoder can tell which view a request belongs to. The container geometry (14 bits of width, 13 of height, 6-bit slots) is set by parameters.

Top module: `tva_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs clear: `out_valid`=0, `out_addr`=0, `out_err`=0, and the helper outputs are 0.
- R2: A request with `in_valid`=1 appears on the outputs after exactly one clock edge with `out_valid`=1. At an edge where `in_valid`=0, `out_valid` drops to 0 and all other outputs keep their values whatever the inputs do.
- R3: Format codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page. Their (x shift, y shift, bytes per pixel) are (0,0,1), (0,1,2), (1,1,4) and (6,6,1). Slot width is 1 << (6 − x shift) and slot height is 1 << (6 − y shift), which gives 64/64/32/1 and 64/32/32/1.
- R4: `out_stride` equals 1 << (14 + y shift): 16384, 32768, 32768 and 1048576 for formats 0 to 3.
- R5: The x field is 14 − x shift bits wide and the y field is 13 − y shift bits wide. If x exceeds the all-ones value of its field, or y exceeds the all-ones value of its field, `out_err` is 1 and `out_addr` is 0. The helper outputs still follow the format.
- R6: With orientation 0, the offset in `out_addr[26:0]` is ((y << xbits) + x) << (x shift + y shift). So in page mode the low 12 offset bits are always 0.
- R7: Orientation bit 0 (X mirror) replaces x with xmask − x before packing.
- R8: Orientation bit 1 (Y mirror) replaces y with ymask − y before packing.
- R9: Orientation bit 2 (swap) packs the fields as (x << ybits) + y instead. Mirroring is applied before the swap.
- R10: For an in-range request, `out_addr[31:30]` holds the format code and `out_addr[29:27]` holds the orientation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Format code |
| in_orient | input | 3 | Bit0 X mirror, bit1 Y mirror, bit2 swap |
| in_x | input | 16 | Pixel x coordinate |
| in_y | input | 16 | Pixel y coordinate |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | 32 | Tiled-space address |
| out_err | output | 1 | Coordinate out of range |
| out_slot_w | output | 7 | Slot width in pixels |
| out_slot_h | output | 7 | Slot height in pixels |
| out_bpp | output | 3 | Bytes per pixel |
| out_stride | output | 21 | Row stride in bytes |

## Verification
The assertions assume the format code is always one of the four defined values. This holds because the code is two bits wide. They also assume that the inputs sampled together with the strobe belong to one request. The stimulus changes the inputs only on the falling clock edge and raises the strobe for exactly one cycle per request. It covers in-range and out-of-range coordinates for every format, including the exact field limits, and it changes the inputs while the strobe is low to exercise the hold rule.

// File: rtl/tva_pkg.sv
package tva_pkg;

  typedef enum logic [1:0] {
    FMT_8B   = 2'd0,
    FMT_16B  = 2'd1,
    FMT_32B  = 2'd2,
    FMT_PAGE = 2'd3
  } tva_fmt_e;

  typedef struct packed {
    logic [7:0] xs;
    logic [7:0] ys;
    logic [2:0] bpp;
  } tva_geom_t;

  // Unused low coordinate bits and byte size for each format
  function automatic tva_geom_t tva_geom_of(input tva_fmt_e f,
                                            input logic [7:0] slot_wb,
                                            input logic [7:0] slot_hb);
    tva_geom_t g;
    case (f)
      FMT_8B:   g = '{xs: 8'd0, ys: 8'd0, bpp: 3'd1};
      FMT_16B:  g = '{xs: 8'd0, ys: 8'd1, bpp: 3'd2};
      FMT_32B:  g = '{xs: 8'd1, ys: 8'd1, bpp: 3'd4};
      default:  g = '{xs: slot_wb, ys: slot_hb, bpp: 3'd1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/tva_geom.sv
module tva_geom
  import tva_pkg::*;
#(
  parameter int CW_BITS = 14,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int SHW     = 5,
  parameter int SLW     = 7,
  parameter int STW     = 21
) (
  input  logic [1:0]     fmt,
  output logic [SHW-1:0] xs,
  output logic [SHW-1:0] ys,
  output logic [SLW-1:0] slot_w,
  output logic [SLW-1:0] slot_h,
  output logic [2:0]     bpp,
  output logic [STW-1:0] stride
);
  tva_geom_t g;

  always_comb begin
    g      = tva_geom_of(tva_fmt_e'(fmt), 8'(SW_BITS), 8'(SH_BITS));
    xs     = g.xs[SHW-1:0];
    ys     = g.ys[SHW-1:0];
    bpp    = g.bpp;
    slot_w = SLW'(1) << (SHW'(SW_BITS) - xs);
    slot_h = SLW'(1) << (SHW'(SH_BITS) - ys);
    stride = STW'(1) << (SHW'(CW_BITS) + ys);
  end
endmodule

// File: rtl/tva_pack.sv
module tva_pack #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int COORD_W = 16,
  parameter int SHW     = 5,
  parameter int OFF_W   = 27
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [2:0]         orient,
  input  logic [SHW-1:0]     xs,
  input  logic [SHW-1:0]     ys,
  output logic [OFF_W-1:0]   offset,
  output logic               err
);
  localparam int BASE_W = (COORD_W > CW_BITS + CH_BITS) ? COORD_W : CW_BITS + CH_BITS;
  localparam int WW     = BASE_W + 1;

  logic [SHW-1:0] xb, yb;
  logic [WW-1:0]  xw, yw, xmask, ymask, xm, ym, packed_v, shifted;

  always_comb begin
    xb      = SHW'(CW_BITS) - xs;
    yb      = SHW'(CH_BITS) - ys;
    xmask   = (WW'(1) << xb) - WW'(1);
    ymask   = (WW'(1) << yb) - WW'(1);
    xw      = WW'(x);
    yw      = WW'(y);
    err     = (xw > xmask) || (yw > ymask);
    xm      = orient[0] ? (xmask - xw) : xw;
    ym      = orient[1] ? (ymask - yw) : yw;
    packed_v = orient[2] ? ((xm << yb) + ym) : ((ym << xb) + xm);
    shifted = packed_v << (xs + ys);
    offset  = shifted[OFF_W-1:0];
  end
endmodule

// File: rtl/tva_addr_gen.sv
module tva_addr_gen #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int COORD_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [1:0]                   in_fmt,
  input  logic [2:0]                   in_orient,
  input  logic [COORD_W-1:0]           in_x,
  input  logic [COORD_W-1:0]           in_y,
  output logic                         out_valid,
  output logic [CW_BITS+CH_BITS+4:0]   out_addr,
  output logic                         out_err,
  output logic [((SW_BITS>SH_BITS)?SW_BITS:SH_BITS):0] out_slot_w,
  output logic [((SW_BITS>SH_BITS)?SW_BITS:SH_BITS):0] out_slot_h,
  output logic [2:0]                   out_bpp,
  output logic [CW_BITS+SH_BITS:0]     out_stride
);
  localparam int OFF_W  = CW_BITS + CH_BITS;
  localparam int ADDR_W = OFF_W + 5;
  localparam int SHW    = $clog2(CW_BITS + CH_BITS + 1);
  localparam int SLW    = ((SW_BITS > SH_BITS) ? SW_BITS : SH_BITS) + 1;
  localparam int STW    = CW_BITS + SH_BITS + 1;

  logic [SHW-1:0]   xs, ys;
  logic [SLW-1:0]   slot_w_c, slot_h_c;
  logic [2:0]       bpp_c;
  logic [STW-1:0]   stride_c;
  logic [OFF_W-1:0] offset_c;
  logic             err_c;
  logic [ADDR_W-1:0] addr_c;

  tva_geom #(
    .CW_BITS(CW_BITS), .SW_BITS(SW_BITS), .SH_BITS(SH_BITS),
    .SHW(SHW), .SLW(SLW), .STW(STW)
  ) u_geom (
    .fmt(in_fmt), .xs(xs), .ys(ys),
    .slot_w(slot_w_c), .slot_h(slot_h_c), .bpp(bpp_c), .stride(stride_c)
  );

  tva_pack #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .COORD_W(COORD_W),
    .SHW(SHW), .OFF_W(OFF_W)
  ) u_pack (
    .x(in_x), .y(in_y), .orient(in_orient), .xs(xs), .ys(ys),
    .offset(offset_c), .err(err_c)
  );

  assign addr_c = err_c ? '0 : {in_fmt, in_orient, offset_c};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_err    <= 1'b0;
      out_slot_w <= '0;
      out_slot_h <= '0;
      out_bpp    <= '0;
      out_stride <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr   <= addr_c;
        out_err    <= err_c;
        out_slot_w <= slot_w_c;
        out_slot_h <= slot_h_c;
        out_bpp    <= bpp_c;
        out_stride <= stride_c;
      end
    end
  end
endmodule

// File: rtl/tva_checker.sv
module tva_checker #(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int COORD_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [1:0]                 in_fmt,
  input logic [2:0]                 in_orient,
  input logic                       out_valid,
  input logic [CW_BITS+CH_BITS+4:0] out_addr,
  input logic                       out_err,
  input logic [2:0]                 out_bpp
);
  localparam int AW = CW_BITS + CH_BITS + 5;
  localparam int LOWZ = SW_BITS + SH_BITS;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_addr) && $stable(out_err))); // R2
  AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_addr == '0)); // R5
  AST_FMT_TAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_err || (out_addr[AW-1 -: 2] == $past(in_fmt)))); // R10
  AST_ORIENT_TAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_err || (out_addr[AW-3 -: 3] == $past(in_orient)))); // R10
  AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && out_addr[AW-1 -: 2] == 2'd3) |-> (out_addr[LOWZ-1:0] == '0)); // R6
  AST_BPP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_bpp) == 1)); // R3
endmodule

bind tva_addr_gen tva_checker #(
  .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .SW_BITS(SW_BITS),
  .SH_BITS(SH_BITS), .COORD_W(COORD_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
  .in_orient(in_orient), .out_valid(out_valid), .out_addr(out_addr),
  .out_err(out_err), .out_bpp(out_bpp)
);

// File: tb/sim_tva_addr_gen.sv
module sim_tva_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_fmt = '0;
  logic [2:0]  in_orient = '0;
  logic [15:0] in_x = '0, in_y = '0;
  logic        out_valid, out_err;
  logic [31:0] out_addr;
  logic [6:0]  out_slot_w, out_slot_h;
  logic [2:0]  out_bpp;
  logic [20:0] out_stride;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] addr;
    logic        err;
    logic [6:0]  sw, sh;
    logic [2:0]  bpp;
    logic [20:0] stride;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  tva_addr_gen u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err),
    .out_slot_w(out_slot_w), .out_slot_h(out_slot_h),
    .out_bpp(out_bpp), .out_stride(out_stride)
  );

  function automatic exp_t model(logic [1:0] f, logic [2:0] o,
                                 int unsigned x, int unsigned y, string tag);
    exp_t e;
    int unsigned xs, ys, bpp, xb, yb, xmask, ymask, xm, ym, p;
    case (f)
      2'd0: begin xs = 0; ys = 0; bpp = 1; end
      2'd1: begin xs = 0; ys = 1; bpp = 2; end
      2'd2: begin xs = 1; ys = 1; bpp = 4; end
      default: begin xs = 6; ys = 6; bpp = 1; end
    endcase
    xb = 14 - xs; yb = 13 - ys;
    xmask = (1 << xb) - 1; ymask = (1 << yb) - 1;
    e.err = (x > xmask) || (y > ymask);
    xm = o[0] ? xmask - x : x;
    ym = o[1] ? ymask - y : y;
    p = o[2] ? ((xm << yb) + ym) : ((ym << xb) + xm);
    p = (p << (xs + ys)) & 32'h07FF_FFFF;
    e.addr = e.err ? 32'd0 : {f, o, p[26:0]};
    e.sw = 7'(1 << (6 - xs));
    e.sh = 7'(1 << (6 - ys));
    e.bpp = 3'(bpp);
    e.stride = 21'(1 << (14 + ys));
    e.tag = tag;
    return e;
  endfunction

  task automatic send(logic [1:0] f, logic [2:0] o, int unsigned x, int unsigned y, string tag);
    @(negedge clk);
    in_fmt = f; in_orient = o; in_x = 16'(x); in_y = 16'(y); in_valid = 1'b1;
    sb.push_back(model(f, o, x, y, tag));
    n_vec++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pop expected results as the design produces them
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R2", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(out_addr == e.addr, e.tag, "addr", out_addr, e.addr);
        chk(out_err == e.err, e.tag, "err", 32'(out_err), 32'(e.err));
        chk(out_slot_w == e.sw, "R3", "slot_w", 32'(out_slot_w), 32'(e.sw));
        chk(out_slot_h == e.sh, "R3", "slot_h", 32'(out_slot_h), 32'(e.sh));
        chk(out_bpp == e.bpp, "R3", "bpp", 32'(out_bpp), 32'(e.bpp));
        chk(out_stride == e.stride, "R4", "stride", 32'(out_stride), 32'(e.stride));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    n_vec++;  // R1 reset state
    chk(out_valid == 0 && out_addr == 0 && out_err == 0 && out_stride == 0,
        "R1", "reset outputs", out_addr, 32'd0);
    rst = 1'b0;

    // R6 plain packing per format
    send(2'd0, 3'b000, 5, 3, "R6");
    send(2'd1, 3'b000, 100, 200, "R6");
    send(2'd2, 3'b000, 8191, 4095, "R6");
    send(2'd3, 3'b000, 255, 127, "R6");
    send(2'd0, 3'b000, 16383, 8191, "R6");
    // R7 / R8 mirrors, R9 swap
    send(2'd0, 3'b001, 5, 3, "R7");
    send(2'd2, 3'b001, 0, 10, "R7");
    send(2'd0, 3'b010, 5, 3, "R8");
    send(2'd1, 3'b010, 7, 0, "R8");
    send(2'd0, 3'b100, 5, 3, "R9");
    send(2'd3, 3'b111, 17, 9, "R9");
    send(2'd1, 3'b101, 1234, 567, "R9");
    // R10 tags on every orientation
    for (int o = 0; o < 8; o++) send(2'd2, 3'(o), 40, 50, "R10");
    // R5 range limits
    send(2'd0, 3'b000, 16384, 0, "R5");
    send(2'd0, 3'b000, 0, 8192, "R5");
    send(2'd2, 3'b001, 8192, 0, "R5");
    send(2'd1, 3'b000, 0, 4096, "R5");
    send(2'd3, 3'b000, 256, 0, "R5");
    send(2'd3, 3'b010, 0, 128, "R5");
    send(2'd3, 3'b000, 65535, 65535, "R5");
    idle();
    repeat (2) @(negedge clk);

    // R2 hold while strobe low
    send(2'd1, 3'b011, 321, 99, "R2");
    idle();
    @(negedge clk);
    held = out_addr;
    in_fmt = 2'd3; in_orient = 3'b111; in_x = 16'd9; in_y = 16'd9;
    repeat (3) @(negedge clk);
    n_vec++;
    chk(out_addr == held && out_valid == 0, "R2", "hold addr", out_addr, held);

    // Random mix, back to back
    for (int i = 0; i < 300; i++) begin
      logic [1:0] f;
      f = 2'($urandom_range(0, 3));
      if (f == 2'd3)
        send(f, 3'($urandom_range(0, 7)), $urandom_range(0, 270), $urandom_range(0, 135), "R6");
      else
        send(f, 3'($urandom_range(0, 7)), $urandom_range(0, 16400), $urandom_range(0, 8200), "R9");
    end
    idle();
    repeat (3) @(negedge clk);
    n_vec++;
    chk(sb.size() == 0, "R2", "results outstanding", 32'(sb.size()), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule